// File: doc/BRIEF.md
# Paced Serial-Controller Register Bank

This block is the byte-wide register file of a classic asynchronous serial controller. A CPU reaches it through a simple strobe bus with a 3-bit offset. Received bytes arrive from a source that offers valid and data and takes a pop. Transmitted bytes leave to a sink as a one-cycle valid with data, and the sink is taken to accept every byte. The block decodes the divisor-latch switch, the data and enable registers, the interrupt identification and FIFO-control offset, line control, modem control, the two status registers and a scratch byte. It drives one level interrupt line.

Interrupt delivery is paced. Every data access that asks for a new interrupt starts a hold-off timer of `HOLDOFF_CYC` cycles, one timer for receive and one for transmit. When a timer runs out, its pending flag is set, but only if the matching enable bit is still on. A busy driver that drains the receive data is therefore not re-interrupted at once. Turning on the transmit interrupt gives an interrupt at once only when at least the hold-off interval has passed since the last transmit interrupt was posted.

Top module: `ser_regbank`

## Requirements
- R1: After reset the interrupt output is 0. Identification reads 0x01. Enable, line control, modem control, modem status and scratch read 0x00. Line status reads 0x60. No byte has been sent.
- R2: When line-control bit 7 is set, offset 0 reads and writes the divisor low byte and offset 1 the divisor high byte. In that state no byte is sent, nothing is popped and the enable register is untouched. When bit 7 is clear, offset 0 is data and offset 1 is the interrupt enable register (bit 0 receive, bit 1 transmit, 4 bits stored).
- R3: Offset 2 reads 0x04 when a receive interrupt is pending, since receive has priority. It reads 0x02 when only a transmit interrupt is pending and 0x01 when none is pending.
- R4: Reading offset 2 while it reports 0x02 clears the transmit pending flag. A read that reports 0x04 clears neither flag.
- R5: Reading data pops one byte if one is present and returns 0 if none is. It clears the receive pending flag. With receive enabled it restarts the receive timer, and at expiry the flag is set only if data is then present.
- R6: Writing data produces a one-cycle transmit valid that carries the byte. It clears the transmit pending flag and, with transmit enabled, restarts the transmit timer.
- R7: A pending flag is set exactly `HOLDOFF_CYC` clock edges after the edge that started its timer. Restarting a running timer begins the full interval again.
- R8: Writing the enable register with bit 1 set posts a transmit interrupt in the same cycle if at least `HOLDOFF_CYC` cycles have passed since the last transmit interrupt was posted (reset counts as long ago). Otherwise it starts the timer. Writing bit 1 clear cancels the timer and clears the transmit flag.
- R9: Writing the enable register with bit 0 set while data is present starts the receive timer. Any other enable write cancels it and clears the receive flag. A rise of receive-valid while receive is enabled starts the timer.
- R10: Line status reads 0x60, with bit 0 set while receive data is present. Writes to offsets 5 and 6 have no effect, and modem status reads 0.
- R11: Writing 0x1A to modem control stores 0x9A. Any other value leaves it unchanged.
- R12: The interrupt output is high exactly while a pending flag is set. A flag is never set while its enable bit is clear.
- R13: Offset 7 is a read/write scratch byte. Writes to offset 2 do not change what offset 2 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the current offset |
| rx_valid | input | 1 | Receive byte available |
| rx_data | input | 8 | Receive byte |
| rx_pop | output | 1 | Consume the receive byte |
| tx_valid | output | 1 | Transmit byte strobe |
| tx_data | output | 8 | Transmit byte |
| irq | output | 1 | Level interrupt |

## Verification
The bench counts edges from the edge that starts each hold-off timer and samples the interrupt on every cycle of the window. A timer that is one cycle short or long, or that does not restart when a second transmit write arrives, shows as an early or late rise. It enables transmit twice, once shortly after an interrupt and once well after, so a design that ignores the elapsed-time rule fires too soon or waits needlessly. It fills both pending flags to check receive priority and that only a transmit report is cleared by the identification read. It drains a two-byte queue to check that the receive timer restarts and that expiry on an empty queue stays quiet.

// File: rtl/ser_regbank_pkg.sv
package ser_regbank_pkg;
   localparam int unsigned DATA_W = 8;
   typedef logic [2:0]        reg_off_t;
   typedef logic [DATA_W-1:0] byte_t;

   // offsets whose meaning is part of the compatible map
   localparam reg_off_t OFF_DATA  = 3'd0;
   localparam reg_off_t OFF_IEN   = 3'd1;
   localparam reg_off_t OFF_IID   = 3'd2;
   localparam reg_off_t OFF_LCTL  = 3'd3;
   localparam reg_off_t OFF_MCTL  = 3'd4;
   localparam reg_off_t OFF_LSTAT = 3'd5;
   localparam reg_off_t OFF_MSTAT = 3'd6;
   localparam reg_off_t OFF_SCR   = 3'd7;

   localparam int unsigned IEN_RX_BIT  = 0;
   localparam int unsigned IEN_TX_BIT  = 1;
   localparam int unsigned LCTL_DIV_BIT = 7;

   localparam byte_t IID_NONE   = 8'h01;
   localparam byte_t IID_TX     = 8'h02;
   localparam byte_t IID_RX     = 8'h04;
   localparam byte_t LSTAT_IDLE = 8'h60;
   localparam byte_t MCTL_KEY   = 8'h1A;
   localparam byte_t MCTL_STORE = 8'h9A;

   typedef enum int unsigned { CH_RX = 0, CH_TX = 1, CH_NUM = 2 } chan_e;
endpackage

// File: rtl/ser_holdoff_timer.sv
module ser_holdoff_timer #(
   parameter int unsigned HOLDOFF_CYC = 23
) (
   input  logic clk,
   input  logic rst_n,
   input  logic arm_i,
   input  logic cancel_i,
   output logic fire_o
);
   localparam int unsigned CNT_W = $clog2(HOLDOFF_CYC + 1);
   localparam logic [CNT_W-1:0] LOAD = CNT_W'(HOLDOFF_CYC);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(1);

   logic             active_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         active_q <= 1'b0;
         cnt_q    <= '0;
      end else if (arm_i) begin
         active_q <= 1'b1;
         cnt_q    <= LOAD;
      end else if (cancel_i) begin
         active_q <= 1'b0;
      end else if (active_q) begin
         if (cnt_q == LAST) active_q <= 1'b0;
         else               cnt_q    <= cnt_q - LAST;
      end
   end

   // a restart or a cancel in the same cycle wins over expiry
   assign fire_o = active_q && (cnt_q == LAST) && !arm_i && !cancel_i;

   AST_TMR_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
      (arm_i && (HOLDOFF_CYC > 1)) |=> !fire_o); // R7
   AST_TMR_CANCEL: assert property (@(posedge clk) disable iff (!rst_n)
      (cancel_i && !arm_i) |=> !fire_o); // R8
endmodule

// File: rtl/ser_cfg_regs.sv
module ser_cfg_regs
   import ser_regbank_pkg::*;
#(
   parameter int unsigned IEN_W       = 4,
   parameter bit          HAS_SCRATCH = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  reg_off_t         off,
   input  byte_t            wdata,
   output logic [IEN_W-1:0] ien_o,
   output byte_t            lctl_o,
   output byte_t            div_lo_o,
   output byte_t            div_hi_o,
   output byte_t            mctl_o,
   output byte_t            scr_o
);
   logic div_sel;
   assign div_sel = lctl_o[LCTL_DIV_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ien_o    <= '0;
         lctl_o   <= '0;
         div_lo_o <= '0;
         div_hi_o <= '0;
         mctl_o   <= '0;
      end else if (wr_en) begin
         case (off)
            OFF_DATA: if (div_sel) div_lo_o <= wdata;
            OFF_IEN:  if (div_sel) div_hi_o <= wdata;
                      else         ien_o    <= wdata[IEN_W-1:0];
            OFF_LCTL: lctl_o <= wdata;
            OFF_MCTL: if (wdata == MCTL_KEY) mctl_o <= MCTL_STORE;
            default: ;
         endcase
      end
   end

   generate
      if (HAS_SCRATCH) begin : g_scr
         always_ff @(posedge clk) begin
            if (!rst_n)                         scr_o <= '0;
            else if (wr_en && off == OFF_SCR)   scr_o <= wdata;
         end
      end else begin : g_no_scr
         assign scr_o = '0;
      end
   endgenerate

   AST_MCTL_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && off == OFF_MCTL && wdata != MCTL_KEY) |=> $stable(mctl_o)); // R11
endmodule

// File: rtl/ser_regbank.sv
module ser_regbank
   import ser_regbank_pkg::*;
#(
   parameter int unsigned HOLDOFF_CYC = 23,
   parameter int unsigned IEN_W       = 4,
   parameter bit          HAS_SCRATCH = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       bus_sel,
   input  logic       bus_wr,
   input  logic [2:0] bus_addr,
   input  logic [7:0] bus_wdata,
   output logic [7:0] bus_rdata,
   input  logic       rx_valid,
   input  logic [7:0] rx_data,
   output logic       rx_pop,
   output logic       tx_valid,
   output logic [7:0] tx_data,
   output logic       irq
);
   localparam int unsigned SINCE_W = $clog2(HOLDOFF_CYC + 1);
   localparam logic [SINCE_W-1:0] SINCE_SAT = SINCE_W'(HOLDOFF_CYC);

   initial begin
      assert (HOLDOFF_CYC >= 1 && HOLDOFF_CYC < 65536);
      assert (IEN_W >= 2 && IEN_W <= DATA_W);
   end

   logic [IEN_W-1:0] ien;
   byte_t lctl, div_lo, div_hi, mctl, scr;
   logic  rd_acc, wr_acc, div_sel;
   logic  data_rd, data_wr, ien_wr, iid_rd;

   assign rd_acc  = bus_sel && !bus_wr;
   assign wr_acc  = bus_sel && bus_wr;
   assign div_sel = lctl[LCTL_DIV_BIT];
   assign data_rd = rd_acc && bus_addr == OFF_DATA && !div_sel;
   assign data_wr = wr_acc && bus_addr == OFF_DATA && !div_sel;
   assign ien_wr  = wr_acc && bus_addr == OFF_IEN  && !div_sel;
   assign iid_rd  = rd_acc && bus_addr == OFF_IID;

   ser_cfg_regs #(.IEN_W(IEN_W), .HAS_SCRATCH(HAS_SCRATCH)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_acc), .off(bus_addr), .wdata(bus_wdata),
      .ien_o(ien), .lctl_o(lctl), .div_lo_o(div_lo), .div_hi_o(div_hi),
      .mctl_o(mctl), .scr_o(scr)
   );

   // ---------------- interrupt pacing ----------------
   logic [CH_NUM-1:0] t_arm, t_cancel, t_fire;
   logic rx_valid_q, rx_rise, rx_pend_q, tx_pend_q;
   logic ien_rx, ien_tx, new_rx_en, new_tx_en;
   logic [SINCE_W-1:0] since_q;
   logic tx_expired, tx_now, tx_set, tx_clr, rx_set, rx_clr;

   assign ien_rx    = ien[IEN_RX_BIT];
   assign ien_tx    = ien[IEN_TX_BIT];
   assign new_rx_en = bus_wdata[IEN_RX_BIT];
   assign new_tx_en = bus_wdata[IEN_TX_BIT];
   assign rx_rise   = rx_valid && !rx_valid_q;
   assign tx_expired = (since_q >= SINCE_SAT);
   assign tx_now     = ien_wr && new_tx_en && tx_expired;

   assign t_arm[CH_RX]    = (data_rd && ien_rx) || (ien_wr && new_rx_en && rx_valid)
                          || (rx_rise && ien_rx && !ien_wr);
   assign t_cancel[CH_RX] = ien_wr && !(new_rx_en && rx_valid);
   assign t_arm[CH_TX]    = (data_wr && ien_tx) || (ien_wr && new_tx_en && !tx_expired);
   assign t_cancel[CH_TX] = ien_wr && (!new_tx_en || tx_expired);

   generate
      for (genvar ch = 0; ch < CH_NUM; ch++) begin : g_tmr
         ser_holdoff_timer #(.HOLDOFF_CYC(HOLDOFF_CYC)) u_tmr (
            .clk(clk), .rst_n(rst_n), .arm_i(t_arm[ch]),
            .cancel_i(t_cancel[ch]), .fire_o(t_fire[ch])
         );
      end
   endgenerate

   assign rx_set = t_fire[CH_RX] && ien_rx && rx_valid;
   assign rx_clr = data_rd || (ien_wr && !new_rx_en);
   assign tx_set = tx_now || (t_fire[CH_TX] && ien_tx);
   assign tx_clr = data_wr || (ien_wr && !new_tx_en) || (iid_rd && !rx_pend_q && tx_pend_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rx_valid_q <= 1'b0;
         rx_pend_q  <= 1'b0;
         tx_pend_q  <= 1'b0;
         since_q    <= SINCE_SAT;
      end else begin
         rx_valid_q <= rx_valid;
         if (rx_set)      rx_pend_q <= 1'b1;
         else if (rx_clr) rx_pend_q <= 1'b0;
         if (tx_set)      tx_pend_q <= 1'b1;
         else if (tx_clr) tx_pend_q <= 1'b0;
         if (tx_set)               since_q <= '0;
         else if (!tx_expired)     since_q <= since_q + 1'b1;
      end
   end

   assign irq = rx_pend_q || tx_pend_q;

   // ---------------- data path and read mux ----------------
   byte_t iid_val;
   assign iid_val  = rx_pend_q ? IID_RX : (tx_pend_q ? IID_TX : IID_NONE);
   assign rx_pop   = data_rd && rx_valid;
   assign tx_valid = data_wr;
   assign tx_data  = bus_wdata;

   always_comb begin
      case (bus_addr)
         OFF_DATA:  bus_rdata = div_sel ? div_lo : (rx_valid ? rx_data : '0);
         OFF_IEN:   bus_rdata = div_sel ? div_hi : {{(DATA_W-IEN_W){1'b0}}, ien};
         OFF_IID:   bus_rdata = iid_val;
         OFF_LCTL:  bus_rdata = lctl;
         OFF_MCTL:  bus_rdata = mctl;
         OFF_LSTAT: bus_rdata = LSTAT_IDLE | {7'd0, rx_valid};
         OFF_MSTAT: bus_rdata = '0;
         default:   bus_rdata = scr;
      endcase
   end

   AST_DATA_WR_CLR_TX: assert property (@(posedge clk) disable iff (!rst_n)
      data_wr |=> !tx_pend_q); // R6
   AST_DATA_RD_CLR_RX: assert property (@(posedge clk) disable iff (!rst_n)
      data_rd |=> !rx_pend_q); // R5
   AST_IID_KEEPS_RX: assert property (@(posedge clk) disable iff (!rst_n)
      (iid_rd && rx_pend_q) |=> rx_pend_q); // R4
   AST_TX_OFF_CLR: assert property (@(posedge clk) disable iff (!rst_n)
      (ien_wr && !new_tx_en) |=> !tx_pend_q); // R8
   AST_RX_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      rx_pend_q |-> ien_rx); // R12
   AST_TX_PEND_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
      tx_pend_q |-> ien_tx); // R12
endmodule

// File: tb/tb_ser_regbank.sv
module tb_ser_regbank;
   localparam int H = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_sel = 1'b0, bus_wr = 1'b0;
   logic [2:0] bus_addr = '0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       rx_valid, rx_pop, tx_valid, irq;
   logic [7:0] rx_data, tx_data;

   int nchk = 0, nerr = 0;
   bit done = 0;
   int head = 0, tail = 0;
   logic [7:0] qmem [16];
   int tx_cnt = 0;
   logic [7:0] tx_last = '0;
   logic [7:0] v;

   always #5 clk = ~clk;

   assign rx_valid = (head != tail);
   assign rx_data  = qmem[head & 15];

   always @(posedge clk) if (rx_pop) head <= head + 1;
   always @(posedge clk) if (tx_valid) begin tx_cnt <= tx_cnt + 1; tx_last <= tx_data; end

   ser_regbank #(.HOLDOFF_CYC(H)) dut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_pop(rx_pop),
      .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
   );

   task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s: actual=%02h expected=%02h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [7:0] d);
      @(negedge clk); bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
      @(negedge clk); bus_sel = 0; bus_wr = 0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [7:0] d);
      @(negedge clk); bus_sel = 1; bus_wr = 0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk); bus_sel = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic push(input logic [7:0] b);
      @(negedge clk); qmem[tail & 15] = b; tail = tail + 1;
   endtask

   // after a write task: irq low for H-1 more negedges, high at the H-th
   task automatic irq_window(input string tag);
      for (int i = 1; i < H; i++) begin @(negedge clk); chk(tag, {7'd0, irq}, 8'h00); end
      @(negedge clk); chk(tag, {7'd0, irq}, 8'h01);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      nchk++; nerr++;
      $display("FAIL watchdog: actual=hung expected=done");
      finish_run();
   end

   initial begin
      idle(3); rst_n = 1;
      // R1 reset state
      chk("R1 irq", {7'd0, irq}, 8'h00);
      rd(3'd2, v); chk("R1 iid", v, 8'h01);
      rd(3'd1, v); chk("R1 ien", v, 8'h00);
      rd(3'd3, v); chk("R1 lctl", v, 8'h00);
      rd(3'd4, v); chk("R1 mctl", v, 8'h00);
      rd(3'd5, v); chk("R1 lstat", v, 8'h60);
      rd(3'd7, v); chk("R1 scr", v, 8'h00);
      rd(3'd0, v); chk("R5 empty read", v, 8'h00);
      chk("R1 no tx", tx_cnt[7:0], 8'h00);

      // R2 divisor remap
      wr(3'd3, 8'h83); wr(3'd0, 8'h12); wr(3'd1, 8'h34);
      rd(3'd0, v); chk("R2 div lo", v, 8'h12);
      rd(3'd1, v); chk("R2 div hi", v, 8'h34);
      chk("R2 no tx in div mode", tx_cnt[7:0], 8'h00);
      rd(3'd3, v); chk("R2 lctl", v, 8'h83);
      wr(3'd3, 8'h03);
      rd(3'd1, v); chk("R2 ien untouched", v, 8'h00);
      rd(3'd0, v); chk("R2 data back", v, 8'h00);

      // R13 scratch, fcr; R10 status writes
      wr(3'd7, 8'h5A); rd(3'd7, v); chk("R13 scratch", v, 8'h5A);
      wr(3'd2, 8'hC7); rd(3'd2, v); chk("R13 fcr ignored", v, 8'h01);
      wr(3'd6, 8'hFF); rd(3'd6, v); chk("R10 mstat", v, 8'h00);
      wr(3'd5, 8'h00); rd(3'd5, v); chk("R10 lstat", v, 8'h60);

      // R11 modem control key
      wr(3'd4, 8'h05); rd(3'd4, v); chk("R11 other ignored", v, 8'h00);
      wr(3'd4, 8'h1A); rd(3'd4, v); chk("R11 key", v, 8'h9A);
      wr(3'd4, 8'h03); rd(3'd4, v); chk("R11 keep", v, 8'h9A);

      // R8 immediate after reset, R3/R4 identification
      wr(3'd1, 8'h02); chk("R8 immediate", {7'd0, irq}, 8'h01);
      rd(3'd2, v); chk("R3 tx id", v, 8'h02);
      rd(3'd2, v); chk("R4 tx cleared", v, 8'h01);
      chk("R12 irq low", {7'd0, irq}, 8'h00);
      wr(3'd1, 8'h02);              // too soon: delayed
      irq_window("R8 delayed R7");
      rd(3'd2, v); chk("R4 tx id", v, 8'h02);

      // R8 immediate again after long gap
      idle(H + 4);
      wr(3'd1, 8'h00); wr(3'd1, 8'h02);
      chk("R8 immediate expired", {7'd0, irq}, 8'h01);
      rd(3'd2, v); chk("R4 clear", v, 8'h02);

      // R6 transmit and R7 timing, restart
      wr(3'd0, 8'h3C);
      chk("R6 tx data", tx_last, 8'h3C);
      chk("R6 tx count", tx_cnt[7:0], 8'h01);
      irq_window("R6 R7 thr arm");
      rd(3'd2, v); chk("R3 tx id", v, 8'h02);
      wr(3'd0, 8'h11); idle(2); wr(3'd0, 8'h22);
      irq_window("R7 restart");
      rd(3'd2, v); chk("R4 clear", v, 8'h02);
      chk("R6 tx count", tx_cnt[7:0], 8'h03);
      chk("R6 tx data", tx_last, 8'h22);

      // R8 disable cancels
      wr(3'd0, 8'h44); idle(2); wr(3'd1, 8'h00);
      idle(H + 4); chk("R8 cancelled", {7'd0, irq}, 8'h00);
      rd(3'd2, v); chk("R8 none", v, 8'h01);

      // R9 receive enable with data
      push(8'hA5); idle(H + 3);
      chk("R12 disabled no irq", {7'd0, irq}, 8'h00);
      rd(3'd5, v); chk("R10 ready", v, 8'h61);
      wr(3'd1, 8'h01);
      irq_window("R9 enable arms");
      rd(3'd2, v); chk("R3 rx id", v, 8'h04);
      wr(3'd1, 8'h00); chk("R9 disable clears", {7'd0, irq}, 8'h00);
      idle(H + 2); chk("R9 stays off", {7'd0, irq}, 8'h00);

      // R3 priority, R4 rx not cleared, R5 pop
      wr(3'd1, 8'h03); chk("R8 tx immediate", {7'd0, irq}, 8'h01);
      idle(H);
      rd(3'd2, v); chk("R3 rx priority", v, 8'h04);
      rd(3'd2, v); chk("R4 rx kept", v, 8'h04);
      rd(3'd0, v); chk("R5 pop", v, 8'hA5);
      chk("R12 tx still", {7'd0, irq}, 8'h01);
      rd(3'd2, v); chk("R3 tx after rx", v, 8'h02);
      rd(3'd2, v); chk("R4 cleared", v, 8'h01);
      idle(H + 2); chk("R5 no data at expiry", {7'd0, irq}, 8'h00);
      rd(3'd5, v); chk("R10 empty", v, 8'h60);

      // R5 re-arm with more data
      wr(3'd1, 8'h01);
      push(8'h61); push(8'h62);
      idle(H + 2); chk("R9 rise arms", {7'd0, irq}, 8'h01);
      rd(3'd0, v); chk("R5 first", v, 8'h61);
      chk("R5 clears", {7'd0, irq}, 8'h00);
      for (int i = 1; i < H - 1; i++) begin @(negedge clk); chk("R5 rearm wait", {7'd0, irq}, 8'h00); end
      idle(2); chk("R5 rearm", {7'd0, irq}, 8'h01);
      rd(3'd0, v); chk("R5 second", v, 8'h62);
      idle(H + 2); chk("R5 drained", {7'd0, irq}, 8'h00);
      rd(3'd0, v); chk("R5 empty", v, 8'h00);

      // R9 arrival while enabled
      push(8'h77);
      for (int i = 1; i <= H; i++) begin @(negedge clk); chk("R9 arrival wait", {7'd0, irq}, 8'h00); end
      @(negedge clk); chk("R9 arrival", {7'd0, irq}, 8'h01);
      rd(3'd0, v); chk("R5 pop", v, 8'h77);

      idle(2);
      finish_run();
   end
endmodule